// File: doc/BRIEF.md
# Port Transmit Rate Limiter

This block throttles the traffic leaving a single output port with a token debt accumulator. Every packet that leaves the port adds a cost to the accumulator. The cost has two parts: a per-word part, which is the per-word cost times the packet's length in 8-byte words, and a per-packet part, which covers the wire overhead that the word count leaves out. In bit-rate use that overhead is 24 bytes: 12 bytes of inter-frame gap, 8 bytes of preamble and 4 bytes of CRC. The accumulator pays back a fixed 16 tokens on every clock and never falls below zero.

The per-packet cost and the burst limit are programmed in units of 256 tokens. The per-word cost is programmed in single tokens. A transmit scheduler sends the port's next packet only while the send-allowed flag is high, which is while the debt is at or below 256 times the burst limit. The burst limit therefore sets how much traffic may leave back to back before limiting begins. A packet that has already started is never cut short: its completion strobe is always charged, even when the charge pushes the debt far above the limit. Setting the per-word cost to zero turns the block into a pure packets-per-second limiter.

Top module: `port_rate_limiter`

## Requirements
- R1: A synchronous active-low reset clears the accumulator to zero, so `send_ok_o` reads 1 in the cycle after reset.
- R2: A clock edge with `sent_i` high adds `word_cost_i * sent_words_i + 256 * pkt_cost_i` to the accumulator. The drain of R3 is applied in the same edge.
- R3: On every clock edge the accumulator first loses 16 tokens. When it holds fewer than 16 tokens it becomes 0 instead.
- R4: `send_ok_o` is 1 exactly when the accumulator is less than or equal to `256 * burst_lim_i`, so a value equal to that bound still allows sending.
- R5: With `word_cost_i` at 0, the length of a packet has no effect, and every packet costs only `256 * pkt_cost_i`.
- R6: A strobe on `sent_i` is charged even while `send_ok_o` is 0.
- R7: When the accumulator would exceed its all-ones value of 2^ACC_W - 1, it holds that value instead of wrapping.
- R8: While `sent_i` is 0, `sent_words_i` has no effect on the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_cost_i | input | PKT_W | Per-packet cost, in units of 256 tokens |
| word_cost_i | input | WRD_W | Per-8-byte-word cost, in tokens |
| burst_lim_i | input | LIM_W | Burst limit, in units of 256 tokens |
| sent_i | input | 1 | One-cycle strobe: one packet has left the port |
| sent_words_i | input | CNT_W | Length of that packet in 8-byte words |
| send_ok_o | output | 1 | High while the port may start another packet |

## Verification
The bench runs an arithmetic model of the debt beside the design and compares `send_ok_o` with the model on every cycle.

A sweep over small settings of the three costs drives two sender patterns:
- a polite sender that sends only while the flag is high, which exercises how the flag paces traffic;
- a greedy sender that sends on every cycle, which proves that charges are applied while blocked.

Further tests cover the following cases:
- A sweep of every word count, each packet followed by a drain back to zero, separates a wrong product or a wrong weighting of 256 from a correct charge.
- Directed packets that land exactly on the bound, and one token above it, tell an inclusive compare from a strict one.
- Strobe-free cycles with a large word count show that the word count is ignored while no packet is sent.
- A long flood of maximum-cost packets separates saturation from wrap-around.

// File: rtl/prl_pkg.sv
// Package: constants and width helpers shared by the port rate limiter.
// Assumes the limit and per-packet cost share one granularity shift.
package prl_pkg;
    // Shift applied to the per-packet cost and to the burst limit (units of 256 tokens)
    localparam int GRAN_SHIFT = 8;

    // Width of one charge, with one extra bit so the two parts add without loss
    function automatic int charge_width(input int wrd_w, input int cnt_w, input int pkt_w);
        int a;
        int b;
        a = wrd_w + cnt_w;
        b = pkt_w + GRAN_SHIFT;
        return ((a > b) ? a : b) + 1;
    endfunction

    // Larger of two widths
    function automatic int max_width(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/prl_charge.sv
// Module: prl_charge
// Works out the token cost of the packet reported in the current cycle.
// Assumes sent_i is a one-cycle strobe and sent_words_i is valid with it;
// when no packet is reported the cost is zero and the word count is ignored.
module prl_charge
    import prl_pkg::*;
#(
    parameter int PKT_W = 8,
    parameter int WRD_W = 8,
    parameter int CNT_W = 6,
    parameter int CHG_W = 17
) (
    input  logic             sent_i,
    input  logic [CNT_W-1:0] sent_words_i,
    input  logic [PKT_W-1:0] pkt_cost_i,
    input  logic [WRD_W-1:0] word_cost_i,
    output logic [CHG_W-1:0] charge_o
);
    localparam int PROD_W = WRD_W + CNT_W;
    localparam int FIX_W  = PKT_W + GRAN_SHIFT;

    logic [PROD_W-1:0] word_part;
    logic [FIX_W-1:0]  fixed_part;

    // Per-word part of the cost, taken from the word count only when a packet is reported
    always_comb begin
        word_part = {{CNT_W{1'b0}}, word_cost_i} * {{WRD_W{1'b0}}, (sent_i ? sent_words_i : '0)};
    end

    // Per-packet part of the cost, scaled to single tokens
    always_comb begin
        fixed_part = {pkt_cost_i, {GRAN_SHIFT{1'b0}}};
    end

    // Sum of both parts, gated by the strobe
    always_comb begin
        if (sent_i) begin
            charge_o = CHG_W'(word_part) + CHG_W'(fixed_part);
        end else begin
            charge_o = '0;
        end
    end
endmodule

// File: rtl/prl_accum.sv
// Module: prl_accum
// Token debt register: each clock removes DRAIN tokens (stopping at zero),
// then adds the charge of this cycle, saturating at the all-ones value.
// Assumes ACC_W > CHG_W so that a single charge always fits.
module prl_accum #(
    parameter int ACC_W = 20,
    parameter int CHG_W = 17,
    parameter int DRAIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHG_W-1:0] charge_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] DRAIN_V = ACC_W'(DRAIN);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] drained;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] acc_d;

    // Pay back the fixed drain, never below zero
    always_comb begin
        drained = (acc_q >= DRAIN_V) ? (acc_q - DRAIN_V) : '0;
    end

    // Add the new charge with one guard bit and clamp on overflow
    always_comb begin
        sum   = {1'b0, drained} + (ACC_W + 1)'(charge_i);
        acc_d = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    end

    // Debt register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/prl_gate.sv
// Module: prl_gate
// Compares the debt with the burst limit scaled to single tokens; sending is
// allowed while the debt is at or below that bound. Purely combinational.
module prl_gate
    import prl_pkg::*;
#(
    parameter int ACC_W = 20,
    parameter int LIM_W = 8
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [LIM_W-1:0] burst_lim_i,
    output logic             send_ok_o
);
    localparam int THR_W = LIM_W + GRAN_SHIFT;
    localparam int CMP_W = max_width(ACC_W, THR_W);

    logic [THR_W-1:0] bound;

    // Scale the limit to single tokens and compare inclusively
    always_comb begin
        bound     = {burst_lim_i, {GRAN_SHIFT{1'b0}}};
        send_ok_o = (CMP_W'(acc_i) <= CMP_W'(bound));
    end
endmodule

// File: rtl/port_rate_limiter.sv
// Module: port_rate_limiter
// Rate limiter for one output port. Every reported packet is charged a
// per-packet and a per-word cost, the debt drains DRAIN tokens per clock,
// and send_ok_o stays high while the debt is within the scaled burst limit.
// Assumes the costs and the limit are stable or change only between packets;
// a packet already started is always charged, whatever the flag shows.
module port_rate_limiter
    import prl_pkg::*;
#(
    parameter int PKT_W = 8,
    parameter int WRD_W = 8,
    parameter int CNT_W = 6,
    parameter int LIM_W = 8,
    parameter int ACC_W = 20,
    parameter int DRAIN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PKT_W-1:0] pkt_cost_i,
    input  logic [WRD_W-1:0] word_cost_i,
    input  logic [LIM_W-1:0] burst_lim_i,
    input  logic             sent_i,
    input  logic [CNT_W-1:0] sent_words_i,
    output logic             send_ok_o
);
    localparam int CHG_W = charge_width(WRD_W, CNT_W, PKT_W);

    logic [CHG_W-1:0] charge;
    logic [ACC_W-1:0] acc_q;

    // Cost of the packet reported this cycle
    prl_charge #(
        .PKT_W(PKT_W), .WRD_W(WRD_W), .CNT_W(CNT_W), .CHG_W(CHG_W)
    ) u_charge (
        .sent_i      (sent_i),
        .sent_words_i(sent_words_i),
        .pkt_cost_i  (pkt_cost_i),
        .word_cost_i (word_cost_i),
        .charge_o    (charge)
    );

    // Debt accumulator with drain and saturation
    prl_accum #(
        .ACC_W(ACC_W), .CHG_W(CHG_W), .DRAIN(DRAIN)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .charge_i(charge),
        .acc_o   (acc_q)
    );

    // Send-allowed decision
    prl_gate #(
        .ACC_W(ACC_W), .LIM_W(LIM_W)
    ) u_gate (
        .acc_i      (acc_q),
        .burst_lim_i(burst_lim_i),
        .send_ok_o  (send_ok_o)
    );
endmodule

// File: rtl/prl_checker.sv
// Module: prl_checker
// Property checks for port_rate_limiter, attached with bind below.
module prl_checker #(
    parameter int ACC_W = 20,
    parameter int PKT_W = 8,
    parameter int DRAIN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sent,
    input logic [PKT_W-1:0] pkt_cost,
    input logic [ACC_W-1:0] acc,
    input logic             send_ok
);
    logic rst_prev_q = 1'b0;

    // Remember whether reset was applied at the previous edge
    always_ff @(posedge clk) begin
        rst_prev_q <= ~rst_n;
    end

    // R1: the edge after a reset leaves zero debt and sending allowed
    always_ff @(posedge clk) begin
        if (rst_prev_q) begin
            p_reset_clear_r1: assert (acc == '0 && send_ok)
                else $error("p_reset_clear_r1");
        end
    end

    // R3: with no packet, the debt drops by exactly the drain amount
    p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sent && acc >= ACC_W'(DRAIN)) |=> (acc == $past(acc) - ACC_W'(DRAIN)));

    // R3: with no packet, a small debt goes to zero rather than below it
    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sent && acc < ACC_W'(DRAIN)) |=> (acc == '0));

    // R6: a packet with a nonzero per-packet cost is charged even when blocked
    p_charged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sent && pkt_cost != '0) |=> (acc >= ACC_W'(256)));

    // R7: the debt never drops by more than the drain in one edge (no wrap)
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, acc} + (ACC_W + 1)'(DRAIN) >= {1'b0, $past(acc)}));
endmodule

bind port_rate_limiter prl_checker #(
    .ACC_W(ACC_W), .PKT_W(PKT_W), .DRAIN(DRAIN)
) u_prl_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .sent    (sent_i),
    .pkt_cost(pkt_cost_i),
    .acc     (acc_q),
    .send_ok (send_ok_o)
);

// File: tb/test_port_rate_limiter.sv
// Bench: arithmetic debt model compared with send_ok_o on every cycle.
module test_port_rate_limiter;
    localparam int PKT_W = 8;
    localparam int WRD_W = 8;
    localparam int CNT_W = 6;
    localparam int LIM_W = 8;
    localparam int ACC_W = 20;
    localparam longint ACC_MAX = (longint'(1) << ACC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PKT_W-1:0] pkt_cost = '0;
    logic [WRD_W-1:0] word_cost = '0;
    logic [LIM_W-1:0] burst_lim = '0;
    logic             sent = 1'b0;
    logic [CNT_W-1:0] words = '0;
    logic             send_ok;

    int     total = 0;
    int     bad = 0;
    longint acc_m = 0;
    logic   [15:0] lfsr = 16'hACE1;
    bit     finished = 1'b0;

    port_rate_limiter #(
        .PKT_W(PKT_W), .WRD_W(WRD_W), .CNT_W(CNT_W),
        .LIM_W(LIM_W), .ACC_W(ACC_W), .DRAIN(16)
    ) i_port_rate_limiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_cost_i  (pkt_cost),
        .word_cost_i (word_cost),
        .burst_lim_i (burst_lim),
        .sent_i      (sent),
        .sent_words_i(words),
        .send_ok_o   (send_ok)
    );

    always #2 clk = ~clk;

    function automatic bit exp_ok();
        return acc_m <= longint'(burst_lim) * 256;
    endfunction

    task automatic check(input string tag);
        total++;
        if (send_ok !== exp_ok()) begin
            bad++;
            $display("FAIL %s: send_ok=%0b expected=%0b (model debt %0d)", tag, send_ok, exp_ok(), acc_m);
        end
    endtask

    // One cycle: drive at the falling edge, model the rising edge, check at the next falling edge
    task automatic cyc(input logic s, input int w, input string tag);
        longint d;
        sent  = s;
        words = CNT_W'(w);
        @(posedge clk);
        if (!rst_n) begin
            acc_m = 0;
        end else begin
            d = (acc_m >= 16) ? acc_m - 16 : 0;
            if (s) d = d + longint'(word_cost) * longint'(words) + longint'(pkt_cost) * 256;
            acc_m = (d > ACC_MAX) ? ACC_MAX : d;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic drain_out(input string tag);
        while (acc_m > 0) cyc(1'b0, 0, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: cycles=190000 expected=finish earlier");
        finish_run();
    end

    initial begin
        int pc_set[3];
        int wc_set[3];
        int lim_set[3];
        pc_set  = '{0, 1, 3};
        wc_set  = '{0, 1, 5};
        lim_set = '{0, 1, 4};

        // R1: reset state
        @(negedge clk);
        rst_n = 1'b0;
        cyc(1'b0, 0, "R1");
        cyc(1'b0, 0, "R1");
        rst_n = 1'b1;
        cyc(1'b0, 0, "R1");

        // R4: land exactly on the bound, then one token above it
        pkt_cost = 8'd1; word_cost = 8'd0; burst_lim = 8'd1;
        cyc(1'b1, 0, "R4");           // debt 256 == bound: allowed
        cyc(1'b0, 0, "R4");
        drain_out("R4");
        word_cost = 8'd1;
        cyc(1'b1, 1, "R4");           // debt 257 > bound: blocked
        cyc(1'b0, 0, "R4");           // debt 241: allowed again
        drain_out("R4");

        // R8: word count without a strobe has no effect
        burst_lim = 8'd0; word_cost = 8'd255; pkt_cost = 8'd0;
        for (int i = 0; i < 8; i++) cyc(1'b0, 63, "R8");
        cyc(1'b1, 1, "R8");           // debt 255: blocked at limit zero
        drain_out("R8");

        // R2: every word count, each packet alone
        pkt_cost = 8'd2; word_cost = 8'd7; burst_lim = 8'd2;
        for (int w = 0; w < 64; w++) begin
            cyc(1'b1, w, "R2");
            drain_out("R2");
        end

        // R5: zero word cost, packet length irrelevant
        pkt_cost = 8'd1; word_cost = 8'd0; burst_lim = 8'd3;
        for (int i = 0; i < 40; i++) begin
            step_lfsr();
            cyc(exp_ok(), int'(lfsr[5:0]), "R5");
        end
        drain_out("R5");

        // R3/R6: sweep of small settings with polite and greedy senders
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                for (int c = 0; c < 3; c++) begin
                    pkt_cost = PKT_W'(pc_set[a]);
                    word_cost = WRD_W'(wc_set[b]);
                    burst_lim = LIM_W'(lim_set[c]);
                    for (int i = 0; i < 40; i++) begin
                        step_lfsr();
                        cyc(exp_ok() & lfsr[0], int'(lfsr[6:1]), "R3");
                    end
                    for (int i = 0; i < 40; i++) begin
                        step_lfsr();
                        cyc(1'b1, int'(lfsr[6:1]), "R6");
                    end
                    drain_out("R3");
                end
            end
        end

        // R7: flood with maximum-cost packets, then drain through the bound
        pkt_cost = 8'd255; word_cost = 8'd255; burst_lim = 8'd255;
        for (int i = 0; i < 20; i++) cyc(1'b1, 63, "R7");
        while (acc_m > longint'(burst_lim) * 256 - 32) cyc(1'b0, 0, "R7");

        // R1: reset in the middle of a busy period
        burst_lim = 8'd0;
        cyc(1'b1, 63, "R1");
        rst_n = 1'b0;
        cyc(1'b0, 0, "R1");
        rst_n = 1'b1;
        cyc(1'b0, 0, "R1");

        finish_run();
    end
endmodule